// File: doc/BRIEF.md
# Receive Buffer with Sticky Overrun Status

This block is the receive-side storage of a serial port. The bit-level receiver hands over each completed character on a valid/ready stream. The block queues the characters in a first-in first-out buffer, and the CPU drains them on a second valid/ready stream. Beside the buffer sits a 16-bit line status register. Its only live bit is a sticky overrun flag.

A character that completes while the buffer is full is dropped and the buffer is left unchanged. The flag is then set, and `rx_ready` falls, which blocks further reception. The flag goes away only through a handshake. Software first reads the register and sees the flag at 1, and then writes 0 to bit 0. A power-on reset also clears it.

Back-pressure rules on the input stream:
- A character moves only when `rx_valid` and `rx_ready` are both high. `rx_valid` is ignored while `rx_ready` is low.
- `rx_ready` is not a "buffer has room" signal. It is high whenever reception is enabled and no overrun is pending.
- When a character is offered to a full buffer, the transfer still completes, but the character is discarded.

Back-pressure rules on the output stream:
- `out_valid` is high whenever the buffer holds data.
- An entry leaves the buffer on each clock edge where `out_valid` and `out_ready` are both high.

Top module: `rx_overrun_fifo`

## Requirements
- R1: After power-on reset (`rst_n` low), the overrun flag is 0, `reg_rdata` is 0x0000, the buffer is empty, `fifo_count` is 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: Characters leave on `out_data` in arrival order. `out_valid` equals not-empty, `fifo_count` equals the number held, `fifo_full` is high at 16 entries, and an entry is removed on each edge where `out_valid` and `out_ready` are both high.
- R3: A transfer (`rx_valid` and `rx_ready` both high) stores `rx_data` when the buffer is not full, or when it is full and an entry leaves in the same cycle.
- R4: A transfer into a full buffer with no removal in the same cycle discards the character, leaves the contents and `fifo_count` unchanged, and sets the overrun flag on that edge.
- R5: `rx_ready` is 1 exactly when `rx_en` is 1 and the flag is 0. `rx_inhibit` equals the flag. `rx_valid` has no effect while `rx_ready` is 0.
- R6: `reg_rdata` bits 15 to 1 always read as 0, and writes to them have no effect. Bit 0 reads as the overrun flag.
- R7: A register write with bit 0 equal to 1 does not change the flag.
- R8: A write with bit 0 equal to 0 clears the flag only if a read on an earlier cycle returned the flag as 1 after it was last set. Otherwise the flag stays set. A clearing write disarms the handshake, and a new setting of the flag also disarms it. If a set and a clear fall on the same cycle, the set wins.
- R9: Changing `rx_en` never changes the overrun flag.
- R10: Removing entries from the buffer never clears the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rx_en | input | 1 | Reception enable |
| rx_valid | input | 1 | Completed character offered by the receiver |
| rx_data | input | 8 | Character value |
| rx_ready | output | 1 | Block accepts a character this cycle |
| rx_inhibit | output | 1 | Overrun pending; receiver must stall |
| out_valid | output | 1 | Buffer holds data |
| out_data | output | 8 | Oldest stored character |
| out_ready | input | 1 | CPU takes the oldest character |
| fifo_count | output | 5 | Number of stored characters |
| fifo_empty | output | 1 | Buffer is empty |
| fifo_full | output | 1 | Buffer holds 16 characters |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 16 | Status register write data |
| reg_rdata | output | 16 | Status register read data |

## Verification
Some rules are checked by assertions on every cycle:
- a transfer into a full buffer raises the inhibit and freezes the count;
- an inhibited block never grows its count;
- the flag falls only on a cycle after a write of 0;
- removals and toggles of `rx_en` never drop the flag.

Other rules can only be shown by the bench's scenarios, because they depend on history:
- the read-then-write arming, including that a write of 0 without a prior read is refused;
- that a read in the same cycle as the write does not count;
- the arrival order of the data.

// File: rtl/rxof_pkg.sv
package rxof_pkg;
  localparam int unsigned RXOF_DATA_W = 8;
  localparam int unsigned RXOF_DEPTH  = 16;
  localparam int unsigned RXOF_REG_W  = 16;
  localparam int unsigned RXOF_FLAG_BIT = 0;

  typedef struct packed {
    logic set_req;
    logic clr_req;
  } flag_evt_t;
endpackage

// File: rtl/rxof_fifo.sv
module rxof_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_ptr_q == PTR_W'(gi))) store_q[gi] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_data = empty ? '0 : store_q[rd_ptr_q];
  assign count     = cnt_q;
endmodule

// File: rtl/rxof_flag.sv
module rxof_flag
  import rxof_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_evt_t evt,
  input  logic      reg_rd,
  output logic      flag,
  output logic      armed
);
  logic flag_q, arm_q;
  logic clr_ok;

  // a clearing write counts only with an arm recorded on an earlier cycle
  assign clr_ok = evt.clr_req && arm_q && flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (evt.set_req) begin
        flag_q <= 1'b1;          // R8: set beats a clear in the same cycle
        arm_q  <= 1'b0;
      end else if (clr_ok) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (reg_rd && flag_q) begin
        arm_q  <= 1'b1;
      end
    end
  end

  assign flag  = flag_q;
  assign armed = arm_q;
endmodule

// File: rtl/rxof_regif.sv
module rxof_regif
  import rxof_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             flag,
  output logic             clr_req,
  output logic [REG_W-1:0] rdata
);
  // only a zero in the flag position requests a clear; all other bits are dropped
  assign clr_req = reg_wr && !reg_wdata[RXOF_FLAG_BIT];

  always_comb begin
    rdata = '0;
    rdata[RXOF_FLAG_BIT] = flag;
  end
endmodule

// File: rtl/rx_overrun_fifo.sv
module rx_overrun_fifo
  import rxof_pkg::*;
#(
  parameter int unsigned DATA_W = RXOF_DATA_W,
  parameter int unsigned DEPTH  = RXOF_DEPTH,
  parameter int unsigned REG_W  = RXOF_REG_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_inhibit,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic [CNT_W-1:0]  fifo_count,
  output logic              fifo_empty,
  output logic              fifo_full,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  logic      flag, armed, xfer, pop, clr_req;
  flag_evt_t evt;

  assign rx_ready   = rx_en && !flag;
  assign xfer       = rx_valid && rx_ready;
  assign pop        = out_ready && !fifo_empty;
  assign evt.set_req = xfer && fifo_full && !pop;
  assign evt.clr_req = clr_req;

  rxof_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(xfer), .push_data(rx_data), .pop(pop),
    .head_data(out_data), .count(fifo_count), .empty(fifo_empty), .full(fifo_full)
  );

  rxof_flag u_flag (
    .clk(clk), .rst_n(rst_n), .evt(evt), .reg_rd(reg_rd),
    .flag(flag), .armed(armed)
  );

  rxof_regif #(.REG_W(REG_W)) u_regif (
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .flag(flag),
    .clr_req(clr_req), .rdata(reg_rdata)
  );

  assign rx_inhibit = flag;
  assign out_valid  = !fifo_empty;
endmodule

// File: rtl/rx_overrun_fifo_chk.sv
module rx_overrun_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned REG_W = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             rx_inhibit,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata
);
  logic took;
  assign took = out_valid && out_ready;

  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && fifo_full && !took) |=> rx_inhibit);

  a_r4_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && fifo_full && !took) |=> (fifo_count == $past(fifo_count)));

  a_r5_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_inhibit && !took) |=> (fifo_count == $past(fifo_count)));

  a_r8_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_inhibit) |-> $past(reg_wr && !reg_wdata[0]));

  a_r9_enable_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && ($past(rx_en) != rx_en)) |=> (rx_inhibit == $past(rx_inhibit)));

  a_r10_pop_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_inhibit && took && !reg_wr) |=> rx_inhibit);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count <= CNT_W'(DEPTH)) && !(fifo_full && fifo_empty));
endmodule

bind rx_overrun_fifo rx_overrun_fifo_chk #(.DEPTH(DEPTH), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_inhibit(rx_inhibit), .out_valid(out_valid), .out_ready(out_ready),
  .fifo_count(fifo_count), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata)
);

// File: tb/rx_overrun_fifo_tb_top.sv
module rx_overrun_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, rx_valid = 1'b0, out_ready = 1'b0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] rx_data = '0;
  logic [15:0] reg_wdata = '0;
  logic rx_ready, rx_inhibit, out_valid, fifo_empty, fifo_full;
  logic [7:0] out_data;
  logic [4:0] fifo_count;
  logic [15:0] reg_rdata;

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0;

  // reference model
  byte unsigned mq[$];
  bit m_flag = 0, m_arm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_overrun_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_inhibit(rx_inhibit), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .fifo_count(fifo_count),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_flag = 0; m_arm = 0;
    end else begin
      bit pop_m, push_m, full_m, set_m, clr_m;
      pop_m  = out_ready && (mq.size() > 0);
      push_m = rx_valid && rx_en && !m_flag;
      full_m = (mq.size() == DEPTH);
      set_m  = push_m && full_m && !pop_m;
      clr_m  = reg_wr && !reg_wdata[0] && m_arm && m_flag;
      if (pop_m) void'(mq.pop_front());
      if (push_m && (!full_m || pop_m)) mq.push_back(rx_data);
      if (set_m) begin m_flag = 1; m_arm = 0; end
      else if (clr_m) begin m_flag = 0; m_arm = 0; end
      else if (reg_rd && m_flag) m_arm = 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk); #1;
    if (cmp_on) begin
      chk("R2", "count", fifo_count, mq.size());
      chk("R2", "empty", fifo_empty, mq.size() == 0);
      chk("R2", "full", fifo_full, mq.size() == DEPTH);
      chk("R2", "out_valid", out_valid, mq.size() != 0);
      if (mq.size() != 0) chk("R2", "out_data", out_data, mq[0]);
      chk("R5", "rx_ready", rx_ready, rx_en && !m_flag);
      chk("R5", "rx_inhibit", rx_inhibit, m_flag);
      chk("R6", "reg_rdata", reg_rdata, {15'b0, m_flag});
    end
  end

  // one clock: inputs held through the edge, then sampled after negedge
  task automatic tick();
    @(posedge clk); @(negedge clk); #2;
  endtask

  task automatic idle();
    rx_valid = 0; out_ready = 0; reg_rd = 0; reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic push(byte unsigned d);
    rx_valid = 1; rx_data = d; tick(); idle();
  endtask

  task automatic pop1();
    out_ready = 1; tick(); idle();
  endtask

  task automatic rd();
    reg_rd = 1; tick(); idle();
  endtask

  task automatic wr(logic [15:0] v);
    reg_wr = 1; reg_wdata = v; tick(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*3); @(negedge clk); #2;
    chk("R1", "reset count", fifo_count, 0);
    chk("R1", "reset empty", fifo_empty, 1);
    chk("R1", "reset full", fifo_full, 0);
    chk("R1", "reset rdata", reg_rdata, 0);
    chk("R1", "reset inhibit", rx_inhibit, 0);
    rst_n = 1; tick(); cmp_on = 1;
    rx_en = 1; tick();

    // R3 and R2: plain push and ordered pop
    for (int i = 0; i < 5; i++) push(8'hA0 + i);
    chk("R3", "count after 5 pushes", fifo_count, 5);
    chk("R2", "head is first", out_data, 8'hA0);
    for (int i = 0; i < 5; i++) begin
      chk("R2", "order", out_data, 8'hA0 + i);
      pop1();
    end
    chk("R2", "drained", fifo_empty, 1);

    // R5: disabled receiver ignores valid
    rx_en = 0; push(8'h55);
    chk("R5", "disabled push ignored", fifo_count, 0);
    rx_en = 1;

    // fill to full, then overrun
    for (int i = 0; i < DEPTH; i++) push(8'h10 + i);
    chk("R2", "full flag", fifo_full, 1);
    push(8'hEE);
    chk("R4", "flag set", reg_rdata, 16'h0001);
    chk("R4", "count kept", fifo_count, DEPTH);
    chk("R4", "head kept", out_data, 8'h10);
    chk("R5", "ready low", rx_ready, 0);

    // R8: write 0 without a prior read
    wr(16'h0000);
    chk("R8", "unarmed write keeps flag", rx_inhibit, 1);

    // R10: pop keeps flag; R5: push while inhibited ignored
    pop1();
    chk("R10", "pop keeps flag", rx_inhibit, 1);
    push(8'h77);
    chk("R5", "inhibited push ignored", fifo_count, DEPTH - 1);

    // R9: toggling enable keeps flag
    rx_en = 0; tick(); rx_en = 1; tick();
    chk("R9", "enable toggle keeps flag", rx_inhibit, 1);

    // R7: armed, then write with bit0=1
    rd();
    wr(16'h0001);
    chk("R7", "write one no effect", rx_inhibit, 1);
    wr(16'hFFFE);
    chk("R8", "armed write clears", rx_inhibit, 0);
    chk("R6", "upper bits ignored", reg_rdata, 16'h0000);

    // R8: read in the same cycle as write does not arm that write
    push(8'h31); push(8'h32);
    chk("R4", "second overrun", rx_inhibit, 1);
    reg_rd = 1; reg_wr = 1; reg_wdata = 16'h0000; tick(); idle();
    chk("R8", "same-cycle read not counted", rx_inhibit, 1);
    wr(16'h0000);
    chk("R8", "cleared after earlier read", rx_inhibit, 0);
    wr(16'h0000); rd();
    chk("R8", "write on clear flag harmless", rx_inhibit, 0);

    // R3: push and pop in same cycle when full
    rx_valid = 1; rx_data = 8'h99; out_ready = 1; tick(); idle();
    chk("R3", "full push with pop accepted", fifo_count, DEPTH);
    chk("R3", "no overrun", rx_inhibit, 0);

    // drain with order checked on every clock
    for (int i = 0; i < DEPTH; i++) pop1();
    chk("R2", "empty at end", fifo_empty, 1);

    // R1: reset in the middle clears everything
    push(8'h01); rst_n = 0; tick();
    chk("R1", "mid reset count", fifo_count, 0);
    rst_n = 1; tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule